// File: doc/BRIEF.md
# Five-Master Bus Arbiter with Selectable Scheduling

The arbiter decides which of five bus masters owns a single shared bus. Each master raises its request line and holds it while it wants the bus. The arbiter answers with a one-hot grant vector. The current owner keeps the bus until it drops its request or pulses the transfer-done input. On that cycle the arbiter takes a new decision, and the new grant appears on the following clock edge. When nobody is asking for the bus, the grant rests on master 0, which acts as the parking owner.

A 32-bit configuration word is written and read through a plain register port. Bit 0 of that word chooses the scheduling policy. With bit 0 set, every requester is equal, and the search starts at the master just after the last one granted. With bit 0 clear, each master carries a 3-bit priority level packed from bit 4 upward, and only requesters at the highest level compete. A shared rotation pointer breaks ties among them. Masters 0 to 4 are, in the base rotation order, the processor, the DMA engine, the secondary bus bridge, the USB controller and the display controller.

A two-state machine controls the arbiter:
- In state PARK nobody owns the bus and the grant sits on master 0. While no request arrives, PARK holds (transition IDLE). Any request takes the machine to BUSY (transition CLAIM).
- In state BUSY the owner holds the bus while it keeps requesting and done stays low (transition HOLD).
- A decision cycle with at least one request moves the grant to the winner, which may be the same owner (transition HANDOVER).
- A decision cycle with no request returns the machine to PARK (transition RELEASE).

Top module: `arb5_top`

## Requirements
- R1: After reset the grant is 5'b00001, the machine is in PARK, and the configuration word reads 32'h0000_0001, which selects round-robin mode with every priority field 0.
- R2: At every clock edge out of reset, exactly one bit of the grant vector is set.
- R3: In BUSY, while the owner keeps its request high and done is low, the grant does not change.
- R4: A grant other than the parking grant goes only to a master whose request was high on the decision cycle. The new grant appears one clock edge after that cycle.
- R5: If no master requests on a decision cycle, the grant returns to 5'b00001 (master 0) on the next edge, even though master 0 is not requesting.
- R6: With configuration bit 0 = 1, the winner is the first requester found when searching upward in index order with wrap-around, starting at the index just after the last master granted. The search starts at index 0 after reset.
- R7: With configuration bit 0 = 0, only requesters at the highest effective level compete. The level for master i is held in bits [4+3i+2:4+3i], and 5 is the highest level while 1 is the lowest.
- R8: In priority mode, requesters sharing the top level are served in the same rotation as R6, so a master that keeps requesting cannot starve a peer at its level.
- R9: A priority field holding 0, 6 or 7 counts as level 1.
- R10: A word written with the write enable high at an edge reads back from the next cycle. Decisions use the new word from the cycle after the write.
- R11: A decision cycle is any cycle in PARK, any cycle with done high, or any cycle in which the owner's request is low. If done is high while the owner still requests, the owner competes again and is searched last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 5 | Request line for each master, index 0 to 4 |
| xfer_done | input | 1 | Pulse from the owner marking the end of its transfer |
| bus_grant | output | 5 | One-hot grant, registered |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wr_data | input | 32 | Configuration word to store |
| cfg_rd_data | output | 32 | Stored configuration word |

## Verification
- All five masters requesting with done pulsed on every cycle must produce a strict 0-1-2-3-4 cycle. This separates a pointer that follows the last winner from a fixed-priority or stuck pointer.
- In priority mode, a mix of levels where two masters share the top level must alternate between just those two. A second mix, where the top-level masters go quiet, shows that the level filter tracks live requests rather than static settings.
- Fields set to 0, 6 and 7 next to a genuine level 2 separate correct clamping from raw comparison.
- A long pseudo-random run of requests, done pulses and configuration rewrites is compared cycle by cycle with an independent model. It exposes holding, parking and handover errors that the directed patterns miss.

// File: rtl/arb5_pkg.sv
package arb5_pkg;

    localparam int unsigned ARB_MASTERS = 5;
    localparam int unsigned PRIO_BITS   = 3;
    localparam int unsigned PRIO_TOP    = 5;
    localparam int unsigned PRIO_LSB    = 4;
    localparam int unsigned MODE_BIT    = 0;
    localparam int unsigned CFG_BITS    = 32;
    localparam logic [31:0] CFG_RESET   = 32'h0000_0001;

    typedef enum logic [0:0] {
        ST_PARK = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

endpackage

// File: rtl/arb5_cfg.sv
module arb5_cfg
    import arb5_pkg::*;
#(
    parameter int unsigned N     = ARB_MASTERS,
    parameter int unsigned PW    = PRIO_BITS,
    parameter int unsigned PTOP  = PRIO_TOP,
    parameter int unsigned PLSB  = PRIO_LSB,
    parameter int unsigned MBIT  = MODE_BIT,
    parameter int unsigned CW    = CFG_BITS,
    parameter logic [CW-1:0] RST = CW'(CFG_RESET)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CW-1:0]   wr_data,
    output logic [CW-1:0]   rd_data,
    output logic            rr_mode,
    output logic [N*PW-1:0] lvl_flat
);

    localparam logic [PW-1:0] LVL_FLOOR = PW'(1);
    localparam logic [PW-1:0] LVL_CEIL  = PW'(PTOP);

    logic [CW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= RST;
        end else if (wr_en) begin
            word_q <= wr_data;
        end
    end

    assign rd_data = word_q;
    assign rr_mode = word_q[MBIT];

    // per-master level decode with clamping of out-of-range fields
    for (genvar gi = 0; gi < N; gi++) begin : g_lvl
        logic [PW-1:0] raw;
        assign raw = word_q[PLSB + gi*PW +: PW];
        assign lvl_flat[gi*PW +: PW] =
            ((raw == '0) || (raw > LVL_CEIL)) ? LVL_FLOOR : raw;

        p_lvl_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_flat[gi*PW +: PW] >= LVL_FLOOR) && (lvl_flat[gi*PW +: PW] <= LVL_CEIL));
    end

    p_write_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    p_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/arb5_lvl_max.sv
module arb5_lvl_max
    import arb5_pkg::*;
#(
    parameter int unsigned N  = ARB_MASTERS,
    parameter int unsigned PW = PRIO_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] lvl_flat,
    output logic [N-1:0]    top_mask
);

    logic [PW-1:0] best;

    // highest level among live requesters
    always_comb begin
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (lvl_flat[i*PW +: PW] > best)) begin
                best = lvl_flat[i*PW +: PW];
            end
        end
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_mask
        assign top_mask[gi] = req[gi] && (lvl_flat[gi*PW +: PW] == best);
    end

    p_mask_in_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (top_mask & ~req) == '0);

    p_mask_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|top_mask));

endmodule

// File: rtl/arb5_rr_pick.sv
module arb5_rr_pick
    import arb5_pkg::*;
#(
    parameter int unsigned N  = ARB_MASTERS,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] start,
    output logic [N-1:0]  pick_oh,
    output logic [IW-1:0] pick_idx,
    output logic          found
);

    // first candidate at or after start, wrapping past N-1
    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        found    = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(start) + k;
            if (j >= int'(N)) begin
                j = j - int'(N);
            end
            if (!found && cand[j]) begin
                found       = 1'b1;
                pick_oh[j]  = 1'b1;
                pick_idx    = IW'(j);
            end
        end
    end

    p_pick_in_cand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh) && ((pick_oh & ~cand) == '0));

    p_pick_found_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand) |-> found);

endmodule

// File: rtl/arb5_top.sv
module arb5_top
    import arb5_pkg::*;
#(
    parameter int unsigned N   = ARB_MASTERS,
    parameter int unsigned PW  = PRIO_BITS,
    parameter int unsigned CW  = CFG_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  bus_req,
    input  logic          xfer_done,
    output logic [N-1:0]  bus_grant,
    input  logic          cfg_wr_en,
    input  logic [CW-1:0] cfg_wr_data,
    output logic [CW-1:0] cfg_rd_data
);

    localparam int unsigned IW      = $clog2(N);
    localparam logic [N-1:0] PARK_OH = N'(1);
    localparam logic [IW-1:0] IDX_LAST = IW'(N - 1);

    arb_state_e    state_q, state_d;
    logic [N-1:0]  grant_q, grant_d;
    logic [IW-1:0] ptr_q, ptr_d;

    logic            rr_mode;
    logic [N*PW-1:0] lvl_flat;
    logic [N-1:0]    top_mask;
    logic [N-1:0]    cand;
    logic [N-1:0]    pick_oh;
    logic [IW-1:0]   pick_idx;
    logic            found;
    logic            owner_req;
    logic            decide;

    arb5_cfg #(
        .N  (N),
        .PW (PW),
        .CW (CW)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .rd_data  (cfg_rd_data),
        .rr_mode  (rr_mode),
        .lvl_flat (lvl_flat)
    );

    arb5_lvl_max #(
        .N  (N),
        .PW (PW)
    ) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .lvl_flat (lvl_flat),
        .top_mask (top_mask)
    );

    assign cand = rr_mode ? bus_req : top_mask;

    arb5_rr_pick #(
        .N  (N),
        .IW (IW)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (cand),
        .start    (ptr_q),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx),
        .found    (found)
    );

    assign owner_req = |(grant_q & bus_req);
    assign decide    = (state_q == ST_PARK) || xfer_done || !owner_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            grant_q <= PARK_OH;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state: IDLE, CLAIM, HOLD, HANDOVER, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PARK: begin
                if (|bus_req) begin
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (decide && !(|bus_req)) begin
                    state_d = ST_PARK;
                end
            end
            default: state_d = ST_PARK;
        endcase
    end

    // outputs: grant and rotation pointer
    always_comb begin
        grant_d = grant_q;
        ptr_d   = ptr_q;
        if (decide) begin
            if (found) begin
                grant_d = pick_oh;
                ptr_d   = (pick_idx == IDX_LAST) ? '0 : pick_idx + 1'b1;
            end else begin
                grant_d = PARK_OH;
            end
        end
    end

    assign bus_grant = grant_q;

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bus_grant) == 1);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && owner_req && !xfer_done) |=> $stable(bus_grant));

    p_req_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bus_grant) && bus_grant != PARK_OH) |-> ((bus_grant & $past(bus_req)) != '0));

    p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && bus_req == '0) |=> (bus_grant == PARK_OH && state_q == ST_PARK));

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= IDX_LAST);

endmodule

// File: tb/arb5_top_tb.sv
module arb5_top_tb;

    localparam int CLK_NS = 10;
    localparam int NM     = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_req = '0;
    logic        xfer_done = 1'b0;
    logic [4:0]  bus_grant;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // reference model state
    logic        m_busy;
    logic [4:0]  m_grant;
    int          m_ptr;
    logic [31:0] m_cfg;
    logic [4:0]  req_prev;

    arb5_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .xfer_done   (xfer_done),
        .bus_grant   (bus_grant),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int lvl_of(logic [31:0] c, int i);
        int v;
        v = int'(c[4 + 3*i +: 3]);
        return ((v == 0) || (v > 5)) ? 1 : v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: model the decision from pre-edge inputs, then advance
    task automatic tick();
        logic [4:0] cand;
        int best;
        bit decide;
        decide = !m_busy || xfer_done || ((m_grant & bus_req) == '0);
        if (decide) begin
            if (bus_req == '0) begin
                m_grant = 5'b00001;
                m_busy  = 0;
            end else begin
                if (m_cfg[0]) begin
                    cand = bus_req;
                end else begin
                    best = 0;
                    for (int i = 0; i < NM; i++)
                        if (bus_req[i] && lvl_of(m_cfg, i) > best) best = lvl_of(m_cfg, i);
                    for (int i = 0; i < NM; i++)
                        cand[i] = bus_req[i] && (lvl_of(m_cfg, i) == best);
                end
                for (int k = 0; k < NM; k++) begin
                    int j;
                    j = (m_ptr + k) % NM;
                    if (cand[j]) begin
                        m_grant = 5'(1 << j);
                        m_busy  = 1;
                        m_ptr   = (j + 1) % NM;
                        break;
                    end
                end
            end
        end
        if (cfg_wr_en) m_cfg = cfg_wr_data;
        req_prev = bus_req;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [31:0] w);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = w;
        tick();
        cfg_wr_en   = 1'b0;
    endtask

    function automatic logic [31:0] prio_word(int l0, int l1, int l2, int l3, int l4);
        return 32'((l0 << 4) | (l1 << 7) | (l2 << 10) | (l3 << 13) | (l4 << 16));
    endfunction

    task automatic t_reset_r1();
        check("R1 grant after reset", 32'(bus_grant), 32'h1);
        check("R1 cfg after reset", cfg_rd_data, 32'h1);
    endtask

    task automatic t_rr_rotation_r6();
        bus_req   = 5'b11111;
        xfer_done = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R6 rotation order", 32'(bus_grant), 32'(1 << (k % NM)));
        end
        xfer_done = 1'b0;
    endtask

    task automatic t_hold_r3();
        logic [4:0] held;
        bus_req = 5'b11111;
        tick();
        held = bus_grant;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R3 grant held", 32'(bus_grant), 32'(held));
        end
        bus_req = 5'b11111 & ~held;
        tick();
        check("R11 handover on drop", 32'(bus_grant), 32'(m_grant));
        check("R4 new owner requested", 32'((bus_grant & req_prev) != 0), 32'h1);
    endtask

    task automatic t_park_r5();
        bus_req = 5'b00000;
        tick();
        check("R5 park with no request", 32'(bus_grant), 32'h1);
        bus_req = 5'b00100;
        tick();
        check("R4 lone requester", 32'(bus_grant), 32'h4);
        xfer_done = 1'b1;
        tick();
        check("R11 regrant same owner", 32'(bus_grant), 32'h4);
        xfer_done = 1'b0;
        bus_req = 5'b00000;
        tick();
        check("R5 park after release", 32'(bus_grant), 32'h1);
        tick();
        check("R5 park stays", 32'(bus_grant), 32'h1);
    endtask

    task automatic t_cfg_rw_r10();
        cfg_write(32'h5A5A_0F30);
        check("R10 readback", cfg_rd_data, 32'h5A5A_0F30);
        cfg_write(32'h0000_0001);
        check("R10 readback restore", cfg_rd_data, 32'h1);
    endtask

    task automatic t_prio_r7();
        logic [4:0] last;
        cfg_write(prio_word(1, 5, 3, 5, 2));
        bus_req   = 5'b11111;
        xfer_done = 1'b1;
        last = '0;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R7 top level only", 32'((bus_grant == 5'b00010) || (bus_grant == 5'b01000)), 32'h1);
            if (k > 0) check("R8 tie rotates", 32'(bus_grant != last), 32'h1);
            check("R8 model match", 32'(bus_grant), 32'(m_grant));
            last = bus_grant;
        end
        bus_req = 5'b10101;
        tick();
        check("R7 level 3 beats 1 and 2", 32'(bus_grant), 32'h4);
        xfer_done = 1'b0;
    endtask

    task automatic t_clamp_r9();
        cfg_write(prio_word(0, 7, 6, 2, 1));
        bus_req   = 5'b01111;
        xfer_done = 1'b1;
        tick();
        check("R9 level 2 beats clamped 7", 32'(bus_grant), 32'h8);
        bus_req = 5'b00111;
        for (int k = 0; k < 6; k++) begin
            tick();
            check("R9 clamped fields rotate", 32'(bus_grant), 32'(m_grant));
        end
        xfer_done = 1'b0;
        cfg_write(32'h0000_0001);
    endtask

    task automatic t_random_r4();
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bus_req   = lfsr[4:0] & {5{lfsr[7] | lfsr[9]}};
            xfer_done = lfsr[11] & lfsr[5];
            if (lfsr[15:12] == 4'hF) begin
                cfg_write({lfsr, lfsr[7:0], lfsr[15:8]});
            end else begin
                tick();
            end
            check("R2 one-hot grant", 32'($countones(bus_grant)), 32'h1);
            check("R11 model match", 32'(bus_grant), 32'(m_grant));
            if (bus_grant != 5'b00001)
                check("R4 grant to requester", 32'((bus_grant & req_prev) != 0 || bus_grant == m_grant), 32'h1);
        end
        bus_req   = '0;
        xfer_done = 1'b0;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R11 actual=running expected=finished");
        report();
    end

    initial begin
        m_busy   = 0;
        m_grant  = 5'b00001;
        m_ptr    = 0;
        m_cfg    = 32'h1;
        req_prev = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_rr_rotation_r6();
        t_hold_r3();
        t_park_r5();
        t_cfg_rw_r10();
        t_prio_r7();
        t_clamp_r9();
        t_random_r4();
        report();
    end

endmodule